// File: doc/BRIEF.md
# Masked Sprite Compositor

This block paints up to 24 sprites of 16x16 pixels over a 96x64 monochrome frame buffer that already holds a background. On a start pulse it walks the sprite attribute records from the highest index to the lowest. For each enabled sprite it reads the position and pattern number. It then fetches the mask and graphic column strips of the sprite pattern and merges them into the frame buffer, one byte at a time, by read-modify-write. Because the lowest index is drawn last, sprite 0 always ends up in front of all other sprites.

All traffic goes through one shared synchronous memory port with a read latency of one cycle. The same port reaches the attribute records, the pattern data (found from a 24-bit sprite base input) and the frame buffer. Each sprite column is mapped onto the frame buffer pages it covers, after flips, graphic inversion and clipping to the visible area. A single-cycle done pulse marks the end of the pass.

Top module: `sprcomp_top`

## Requirements
- R1: After reset, and until the first start, done, mem_en and mem_we are all low.
- R2: A start pulse in the idle state begins one pass over sprites 23 down to 0. When two sprites overlap, the pixel of the lower index wins. At the end of the pass, done is high for exactly one cycle.
- R3: Sprite i has a 4-byte record at 0x1300+4*i, holding X at +0, Y at +1, the pattern number at +2 and the control byte at +3. An enabled sprite costs exactly three more record reads beyond its control byte.
- R4: Bit 3 of the control byte enables the sprite. For a disabled sprite only its control byte is read, and the frame buffer is not touched.
- R5: Sprite pixel (c,r) lands on screen pixel ((X&0x7F)-16+c, (Y&0x7F)-16+r), so bit 7 of each coordinate is ignored.
- R6: The pattern starts at base + 64*pattern. Its 8-byte tiles appear in this order: mask top-left, mask bottom-left, graphic top-left, graphic bottom-left, mask top-right, mask bottom-right, graphic top-right, graphic bottom-right. Byte k of a tile is column k, and bit j of that byte is row j, counted from the top.
- R7: A set mask bit leaves the frame-buffer pixel unchanged. A clear mask bit replaces the pixel with the graphic bit.
- R8: Control bit 2 inverts the graphic bits only. The mask is used unchanged.
- R9: Control bit 0 mirrors the sprite left to right, and control bit 1 mirrors it top to bottom.
- R10: Pixels outside the 96x64 area are never written. No write ever falls outside 0x1000..0x12FF.
- R11: Screen pixel (x,y) is bit y%8 of byte 0x1000 + 96*(y/8) + x. Every write is preceded by a read of the same byte, and it changes only the pixels the sprite covers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a compositing pass when idle |
| spr_base | input | 24 | Base address of the sprite pattern set |
| done | output | 1 | One-cycle pulse at the end of a pass |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write qualifier for mem_en |
| mem_addr | output | 24 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after the access |

## Verification
Errors in the state that tracks the sprite index, column or page show up as bytes that differ from a pixel-level model of the sprite rules. They also show up as wrong counts of record reads, or as writes outside the frame buffer. All of these can be seen only once the pass is over, when the frame buffer is compared. An off-by-one in the vertical byte offset or the flip logic spoils whole sprite columns, so a single sprite placed at a known position exposes it. An error in the drawing order shows only where sprites overlap, and a scene with stacked sprites checks for it.

// File: rtl/sprcomp_pkg.sv
package sprcomp_pkg;
  localparam int SPR_DIM   = 16;
  localparam int TILE_ROWS = 8;
  localparam int CTL_HFLIP = 0;
  localparam int CTL_VFLIP = 1;
  localparam int CTL_INV   = 2;
  localparam int CTL_EN    = 3;

  typedef enum logic [3:0] {
    OP_CTRL, OP_XPOS, OP_YPOS, OP_PAT,
    OP_MTOP, OP_MBOT, OP_GTOP, OP_GBOT, OP_FBUF
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_WAIT, S_CAP, S_COL, S_PAGE,
    S_WR, S_WRD, S_NXPG, S_NXCOL, S_NXSPR, S_FIN
  } state_e;
endpackage

// File: rtl/sprcomp_addr.sv
module sprcomp_addr
  import sprcomp_pkg::*;
#(
  parameter int          AW        = 24,
  parameter int          IDX_W     = 5,
  parameter int unsigned ATTR_BASE = 'h1300,
  parameter int unsigned FB_BASE   = 'h1000,
  parameter int          FB_W      = 96,
  parameter int          VIRT_OFS  = 16
) (
  input  op_e              op,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       pat,
  input  logic [3:0]       scol,
  input  logic [7:0]       xs,
  input  logic [4:0]       vp,
  input  logic [AW-1:0]    spr_base,
  output logic [AW-1:0]    addr
);
  localparam int OFS_PAGES = VIRT_OFS / TILE_ROWS;
  localparam int REC_BYTES = 4;
  localparam int PAT_BYTES = 64;
  localparam int HALF_OFS  = 32;

  logic [AW-1:0] rec_addr, pat_addr, fb_addr;
  logic [1:0]    field;
  logic [1:0]    strip;

  always_comb begin
    case (op)
      OP_XPOS: field = 2'd0;
      OP_YPOS: field = 2'd1;
      OP_PAT:  field = 2'd2;
      default: field = 2'd3;
    endcase
    case (op)
      OP_MBOT: strip = 2'd1;
      OP_GTOP: strip = 2'd2;
      OP_GBOT: strip = 2'd3;
      default: strip = 2'd0;
    endcase
    rec_addr = AW'(ATTR_BASE) + AW'(idx) * AW'(REC_BYTES) + AW'(field);
    pat_addr = spr_base + AW'(pat) * AW'(PAT_BYTES)
             + (scol[3] ? AW'(HALF_OFS) : AW'(0))
             + AW'(strip) * AW'(TILE_ROWS) + AW'(scol[2:0]);
    fb_addr  = AW'(FB_BASE) + AW'((int'(vp) - OFS_PAGES) * FB_W)
             + AW'(int'(xs) - VIRT_OFS);
    case (op)
      OP_CTRL, OP_XPOS, OP_YPOS, OP_PAT: addr = rec_addr;
      OP_FBUF:                           addr = fb_addr;
      default:                           addr = pat_addr;
    endcase
  end
endmodule

// File: rtl/sprcomp_colbuild.sv
module sprcomp_colbuild
  import sprcomp_pkg::*;
#(
  parameter int DIM = SPR_DIM
) (
  input  logic [7:0]     m_top,
  input  logic [7:0]     m_bot,
  input  logic [7:0]     g_top,
  input  logic [7:0]     g_bot,
  input  logic           vflip,
  input  logic           inv,
  output logic [DIM-1:0] mask,
  output logic [DIM-1:0] gfx
);
  logic [DIM-1:0] raw_m, raw_g;
  assign raw_m = DIM'({m_bot, m_top});
  assign raw_g = DIM'({g_bot, g_top});

  for (genvar b = 0; b < DIM; b++) begin : g_row
    assign mask[b] = vflip ? raw_m[DIM-1-b] : raw_m[b];
    assign gfx[b]  = (vflip ? raw_g[DIM-1-b] : raw_g[b]) ^ inv;
  end
endmodule

// File: rtl/sprcomp_merge.sv
module sprcomp_merge
  import sprcomp_pkg::*;
#(
  parameter int DIM = SPR_DIM
) (
  input  logic [DIM-1:0] mask,
  input  logic [DIM-1:0] gfx,
  input  logic [2:0]     off,
  input  logic [1:0]     pk,
  input  logic [7:0]     old_byte,
  output logic [7:0]     new_byte
);
  localparam int WIN   = DIM + TILE_ROWS;
  localparam int PAGES = WIN / TILE_ROWS;

  logic [DIM-1:0] nmask;
  logic [WIN-1:0] wwin, dwin;
  logic [7:0]     wsl [PAGES];
  logic [7:0]     dsl [PAGES];
  logic [7:0]     wen, dat;

  assign nmask = ~mask;
  assign wwin  = WIN'(nmask) << off;
  assign dwin  = WIN'(gfx) << off;

  for (genvar g = 0; g < PAGES; g++) begin : g_page
    assign wsl[g] = wwin[TILE_ROWS*g +: TILE_ROWS];
    assign dsl[g] = dwin[TILE_ROWS*g +: TILE_ROWS];
  end

  always_comb begin
    wen = '0;
    dat = '0;
    for (int g = 0; g < PAGES; g++) begin
      if (int'(pk) == g) begin
        wen = wsl[g];
        dat = dsl[g];
      end
    end
    new_byte = (old_byte & ~wen) | (dat & wen);
  end
endmodule

// File: rtl/sprcomp_top.sv
module sprcomp_top
  import sprcomp_pkg::*;
#(
  parameter int          AW        = 24,
  parameter int          NSPR      = 24,
  parameter int          FB_W      = 96,
  parameter int          FB_H      = 64,
  parameter int          VIRT_OFS  = 16,
  parameter int unsigned ATTR_BASE = 'h1300,
  parameter int unsigned FB_BASE   = 'h1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] spr_base,
  output logic          done,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata
);
  localparam int IDX_W     = $clog2(NSPR);
  localparam int COL_W     = $clog2(SPR_DIM);
  localparam int FB_PAGES  = FB_H / TILE_ROWS;
  localparam int FB_BYTES  = FB_W * FB_PAGES;
  localparam int OFS_PAGES = VIRT_OFS / TILE_ROWS;
  localparam int PK_LAST   = SPR_DIM / TILE_ROWS;
  localparam int PAT_BYTES = 64;

  state_e           st;
  op_e              op;
  logic [IDX_W-1:0] idx;
  logic [6:0]       xv, yv;
  logic [7:0]       pat;
  logic [3:0]       ctrl;
  logic [COL_W-1:0] col;
  logic [1:0]       pk;
  logic [7:0]       m_top, m_bot, g_top, g_bot, old_byte;

  logic [3:0]       scol;
  logic [7:0]       xs;
  logic [4:0]       vp;
  logic             col_vis, pg_vis;
  logic [AW-1:0]    addr_q;
  logic [SPR_DIM-1:0] cmask, cgfx;
  logic [7:0]       new_byte;

  assign scol    = ctrl[CTL_HFLIP] ? ~4'(col) : 4'(col);
  assign xs      = {1'b0, xv} + 8'(col);
  assign vp      = 5'(yv[6:3]) + 5'(pk);
  assign col_vis = (xs >= 8'(VIRT_OFS)) && (xs < 8'(VIRT_OFS + FB_W));
  assign pg_vis  = (vp >= 5'(OFS_PAGES)) && (vp < 5'(OFS_PAGES + FB_PAGES))
                && !((pk == 2'(PK_LAST)) && (yv[2:0] == 3'd0));

  sprcomp_addr #(
    .AW(AW), .IDX_W(IDX_W), .ATTR_BASE(ATTR_BASE), .FB_BASE(FB_BASE),
    .FB_W(FB_W), .VIRT_OFS(VIRT_OFS)
  ) addr_i (
    .op(op), .idx(idx), .pat(pat), .scol(scol), .xs(xs), .vp(vp),
    .spr_base(spr_base), .addr(addr_q)
  );

  sprcomp_colbuild #(.DIM(SPR_DIM)) col_i (
    .m_top(m_top), .m_bot(m_bot), .g_top(g_top), .g_bot(g_bot),
    .vflip(ctrl[CTL_VFLIP]), .inv(ctrl[CTL_INV]),
    .mask(cmask), .gfx(cgfx)
  );

  sprcomp_merge #(.DIM(SPR_DIM)) merge_i (
    .mask(cmask), .gfx(cgfx), .off(yv[2:0]), .pk(pk),
    .old_byte(old_byte), .new_byte(new_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      op        <= OP_CTRL;
      idx       <= '0;
      xv        <= '0;
      yv        <= '0;
      pat       <= '0;
      ctrl      <= '0;
      col       <= '0;
      pk        <= '0;
      m_top     <= '0;
      m_bot     <= '0;
      g_top     <= '0;
      g_bot     <= '0;
      old_byte  <= '0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          idx <= IDX_W'(NSPR - 1);
          op  <= OP_CTRL;
          st  <= S_REQ;
        end
        S_REQ: begin
          mem_en   <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= addr_q;
          st       <= S_WAIT;
        end
        S_WAIT: begin
          mem_en <= 1'b0;
          st     <= S_CAP;
        end
        S_CAP: begin
          case (op)
            OP_CTRL: begin
              ctrl <= mem_rdata[3:0];
              if (mem_rdata[CTL_EN]) begin
                op <= OP_XPOS;
                st <= S_REQ;
              end else begin
                st <= S_NXSPR;
              end
            end
            OP_XPOS: begin xv <= mem_rdata[6:0]; op <= OP_YPOS; st <= S_REQ; end
            OP_YPOS: begin yv <= mem_rdata[6:0]; op <= OP_PAT;  st <= S_REQ; end
            OP_PAT:  begin pat <= mem_rdata; col <= '0; st <= S_COL; end
            OP_MTOP: begin m_top <= mem_rdata; op <= OP_MBOT; st <= S_REQ; end
            OP_MBOT: begin m_bot <= mem_rdata; op <= OP_GTOP; st <= S_REQ; end
            OP_GTOP: begin g_top <= mem_rdata; op <= OP_GBOT; st <= S_REQ; end
            OP_GBOT: begin g_bot <= mem_rdata; pk <= '0; st <= S_PAGE; end
            OP_FBUF: begin old_byte <= mem_rdata; st <= S_WR; end
            default: st <= S_IDLE;
          endcase
        end
        S_COL: if (col_vis) begin
          op <= OP_MTOP;
          st <= S_REQ;
        end else begin
          st <= S_NXCOL;
        end
        S_PAGE: if (pg_vis) begin
          op <= OP_FBUF;
          st <= S_REQ;
        end else begin
          st <= S_NXPG;
        end
        S_WR: begin
          mem_en    <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= addr_q;
          mem_wdata <= new_byte;
          st        <= S_WRD;
        end
        S_WRD: begin
          mem_en <= 1'b0;
          mem_we <= 1'b0;
          st     <= S_NXPG;
        end
        S_NXPG: if (pk == 2'(PK_LAST)) begin
          st <= S_NXCOL;
        end else begin
          pk <= pk + 2'd1;
          st <= S_PAGE;
        end
        S_NXCOL: if (col == COL_W'(SPR_DIM - 1)) begin
          st <= S_NXSPR;
        end else begin
          col <= col + 1'b1;
          st  <= S_COL;
        end
        S_NXSPR: if (idx == '0) begin
          st <= S_FIN;
        end else begin
          idx <= idx - 1'b1;
          op  <= OP_CTRL;
          st  <= S_REQ;
        end
        S_FIN: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [AW-1:0] pat_base_chk;
  logic          pat_read;
  assign pat_base_chk = spr_base + AW'(pat) * AW'(PAT_BYTES);
  assign pat_read     = (op == OP_MTOP) || (op == OP_MBOT) || (op == OP_GTOP) || (op == OP_GBOT);

  AST_WR_IN_FB: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr >= AW'(FB_BASE)) && (mem_addr < AW'(FB_BASE + FB_BYTES))); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R2
  AST_RMW_SAME: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_addr == $past(mem_addr, 3)); // R11
  AST_PAT_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT && pat_read) |-> (mem_addr - pat_base_chk) < AW'(PAT_BYTES)); // R6
  AST_SKIP_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (st == S_CAP && op == OP_CTRL && !mem_rdata[CTL_EN]) |=> ##2
      (done || (mem_en && !mem_we && mem_addr[1:0] == 2'b11))); // R4
endmodule

// File: tb/sprcomp_top_tb.sv
module sprcomp_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_SZ     = 16384;
  localparam int FB0        = 'h1000;
  localparam int ATT0       = 'h1300;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [23:0] spr_base = 24'h2000;
  logic        done, mem_en, mem_we;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  logic [7:0]  mem [MEM_SZ];
  int          n_chk = 0, n_fail = 0;
  int          acc_cnt = 0, attr_cnt = 0, bad_wr = 0;
  logic [31:0] seed = 32'h1234_5678;

  typedef struct { int addr; logic [7:0] exp; string tag; } item_t;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sprcomp_top dut_i (
    .clk(clk), .rst(rst), .start(start), .spr_base(spr_base), .done(done),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      acc_cnt <= acc_cnt + 1;
      if (!mem_we && mem_addr >= 24'(ATT0) && mem_addr < 24'(ATT0 + 96))
        attr_cnt <= attr_cnt + 1;
      if (mem_we && (mem_addr < 24'(FB0) || mem_addr >= 24'(FB0 + 768)))
        bad_wr <= bad_wr + 1;
      if (mem_we && mem_addr < 24'(MEM_SZ)) mem[mem_addr[13:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[13:0]];
    end
  end

  // monitor: compares the frame buffer against queued expectations once a pass ends
  always @(negedge clk) begin
    if (done) begin
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if (mem[it.addr] !== it.exp) begin
          n_fail++;
          $display("FAIL %s fb byte 0x%0h actual 0x%02h expected 0x%02h",
                   it.tag, it.addr, mem[it.addr], it.exp);
        end
      end
    end
  end

  function automatic logic [7:0] rnd8();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed[31:24];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic fill_random(input int lo, input int hi);
    for (int a = lo; a < hi; a++) mem[a] = rnd8();
  endtask

  task automatic clear_attrs();
    for (int a = ATT0; a < ATT0 + 96; a++) mem[a] = 8'h00;
  endtask

  task automatic set_spr(input int i, input int x, input int y, input int t, input int ctl);
    mem[ATT0 + 4*i + 0] = 8'(x);
    mem[ATT0 + 4*i + 1] = 8'(y);
    mem[ATT0 + 4*i + 2] = 8'(t);
    mem[ATT0 + 4*i + 3] = 8'(ctl);
  endtask

  // pixel-level model of the sprite rules, pushes the expected frame buffer
  task automatic push_expected(input string tag);
    logic [7:0] fb [768];
    for (int j = 0; j < 768; j++) fb[j] = mem[FB0 + j];
    for (int i = 23; i >= 0; i--) begin
      int x0, y0, pb;
      logic [7:0] ctl;
      ctl = mem[ATT0 + 4*i + 3];
      if (ctl[3]) begin
        x0 = int'(mem[ATT0 + 4*i] & 8'h7F) - 16;
        y0 = int'(mem[ATT0 + 4*i + 1] & 8'h7F) - 16;
        pb = int'(spr_base) + 64 * int'(mem[ATT0 + 4*i + 2]);
        for (int c = 0; c < 16; c++) begin
          for (int r = 0; r < 16; r++) begin
            int sc, sr, ba, x, y;
            logic m, g;
            sc = ctl[0] ? 15 - c : c;
            sr = ctl[1] ? 15 - r : r;
            ba = pb + (sc >= 8 ? 32 : 0) + (sr >= 8 ? 8 : 0) + (sc % 8);
            m  = mem[ba][sr % 8];
            g  = mem[ba + 16][sr % 8] ^ ctl[2];
            x  = x0 + c;
            y  = y0 + r;
            if (!m && x >= 0 && x < 96 && y >= 0 && y < 64)
              fb[96*(y/8) + x][y%8] = g;
          end
        end
      end
    end
    for (int j = 0; j < 768; j++) begin
      item_t it;
      it.addr = FB0 + j;
      it.exp  = fb[j];
      it.tag  = tag;
      q.push_back(it);
    end
  endtask

  int d_acc, d_attr;

  task automatic run_pass(input string tag);
    int a0, t0, b0;
    push_expected(tag);
    a0 = acc_cnt; t0 = attr_cnt; b0 = bad_wr;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    @(posedge clk iff done);
    @(negedge clk);
    @(negedge clk);
    check(done == 1'b0, "R2 done single cycle", int'(done), 0);
    check(bad_wr == b0, "R10 writes outside frame buffer", bad_wr - b0, 0);
    d_acc  = acc_cnt - a0;
    d_attr = attr_cnt - t0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int a = 0; a < MEM_SZ; a++) mem[a] = 8'h00;
    fill_random(FB0, FB0 + 768);
    fill_random('h2000, 'h2800);
    clear_attrs();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(mem_en == 1'b0, "R1 mem_en after reset", int'(mem_en), 0);
    check(mem_we == 1'b0, "R1 mem_we after reset", int'(mem_we), 0);

    // R4: every sprite disabled, other control bits set
    for (int i = 0; i < 24; i++) set_spr(i, 40, 40, 1, 8'h07);
    run_pass("R4 disabled");
    check(d_acc == 24, "R4 total accesses", d_acc, 24);
    check(d_attr == 24, "R4 record reads", d_attr, 24);

    // R7 R11: one plain sprite, fully visible at an unaligned row
    clear_attrs();
    set_spr(7, 60, 43, 2, 8'h08);
    run_pass("R7 R11 single sprite");
    check(d_attr == 27, "R3 record reads one sprite", d_attr, 27);

    // R8 R9: flips and inversion
    clear_attrs();
    fill_random(FB0, FB0 + 768);
    set_spr(3, 20, 20, 3, 8'h09);
    set_spr(9, 50, 21, 4, 8'h0A);
    set_spr(14, 80, 50, 5, 8'h0C);
    set_spr(20, 100, 60, 6, 8'h0F);
    run_pass("R8 R9 flips invert");

    // R2: stacked sprites at one spot
    clear_attrs();
    set_spr(0, 50, 40, 7, 8'h08);
    set_spr(12, 50, 40, 8, 8'h0C);
    set_spr(23, 50, 40, 9, 8'h0B);
    run_pass("R2 overlap order");

    // R5 R10: edge and wrapped positions
    clear_attrs();
    fill_random(FB0, FB0 + 768);
    set_spr(1, 8'h90, 8'h88, 10, 8'h08);
    set_spr(2, 0, 0, 11, 8'h08);
    set_spr(4, 104, 30, 12, 8'h09);
    set_spr(6, 30, 72, 13, 8'h0A);
    set_spr(8, 127, 127, 14, 8'h08);
    set_spr(10, 8, 8'hC0, 15, 8'h0E);
    run_pass("R5 R10 edges");

    // R6: random scenes, second base address
    for (int k = 0; k < 4; k++) begin
      spr_base = (k % 2 == 0) ? 24'h2000 : 24'h2400;
      fill_random(FB0, FB0 + 768);
      for (int i = 0; i < 24; i++) begin
        logic [7:0] cb;
        cb = rnd8();
        set_spr(i, int'(rnd8()), int'(rnd8()), int'(rnd8() & 8'h0F),
                int'((cb[0] ? 8'h08 : 8'h00) | (cb[7:5] & 8'h07) | (cb & 8'hF0)));
      end
      run_pass("R6 random scene");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule